// File: doc/BRIEF.md
# UART FIFO Control and Ready Signalling

This block sits next to a serial channel and holds the transmit and receive byte queues for it. Each queue is 16 bytes deep by default. A host programs one byte-wide control register through a write strobe. That register enables the queues, clears either queue with a bit that clears itself, selects the ready-signalling mode and picks the receive threshold. The serial shifters and baud timing live elsewhere. They push bytes into the receive queue, pop bytes from the transmit queue, and pulse a receive time-out line when characters sit idle.

Bytes enter each queue over a valid/ready port. A byte is taken on a clock edge where valid and ready are both high. Ready is high while the count is below the current capacity. A sender that holds valid while ready is low loses that byte, and the queue raises a one-cycle overflow flag. Bytes leave through a pop strobe. The head byte is visible combinationally before the pop. Two ready outputs tell a DMA engine when to move data. In single-character mode they track empty/non-empty. In multi-character mode transmit ready marks a full queue, and receive ready falls at the threshold or on a time-out, then stays low until the queue drains.

Top module: `serfifo_ctl`

## Requirements
- R1: After reset the control readback is 0x00, both counts are 0, both input readies are 1, txrdy is 0, rxrdy is 1 and both overflow flags are 0.
- R2: Control readback layout: bit 0 enable, bit 3 mode select, bits 7:6 threshold code, bits 2:1 always read 0. A write with bit 0 = 0 clears the enable bit but leaves bits 7:3 at their old values.
- R3: While enabled, a queue holds up to 16 bytes and returns them in arrival order. While disabled, it holds one byte. Input ready is 1 exactly while the count is below that capacity.
- R4: A push while input ready is 0 is dropped, and the count keeps its value. The overflow flag is 1 for the single cycle after that edge.
- R5: When a queue is empty its output data reads 0x00, and a pop leaves the count at 0.
- R6: A write with bits 0 and 1 set empties the receive queue by the next cycle, even if a receive push occurs in the same cycle. The transmit queue is untouched.
- R7: A write with bits 0 and 2 set empties the transmit queue by the next cycle. The receive queue is untouched.
- R8: A write that clears the enable bit while it was set empties both queues.
- R9: Threshold code 00, 01, 10, 11 selects a receive level of 1, 4, 8, 14 bytes.
- R10: In multi-character mode (enable and bit 3 set), txrdy is 1 only when the transmit queue holds 16 bytes.
- R11: In multi-character mode, rxrdy goes to 0 when the receive count reaches the threshold or during a time-out pulse with data held. It stays 0 until the receive queue is empty, then returns to 1.
- R12: In single-character mode or while disabled, txrdy is 1 when the transmit queue holds any byte, and rxrdy is 0 when the receive queue holds any byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| cfg_q | output | 8 | Control register readback |
| tx_in_valid | input | 1 | Host byte offered to transmit queue |
| tx_in_data | input | 8 | Host byte |
| tx_in_ready | output | 1 | Transmit queue can take a byte |
| tx_pop | input | 1 | Transmit shifter takes the head byte |
| tx_out_data | output | 8 | Transmit head byte (0 when empty) |
| tx_count | output | 5 | Transmit queue occupancy |
| tx_ovf | output | 1 | Transmit push was dropped last cycle |
| rx_in_valid | input | 1 | Received byte offered to receive queue |
| rx_in_data | input | 8 | Received byte |
| rx_in_ready | output | 1 | Receive queue can take a byte |
| rx_pop | input | 1 | Host takes the head byte |
| rx_out_data | output | 8 | Receive head byte (0 when empty) |
| rx_count | output | 5 | Receive queue occupancy |
| rx_ovf | output | 1 | Receive push was dropped last cycle |
| rx_timeout | input | 1 | Receive time-out pulse |
| txrdy | output | 1 | Transmit DMA ready indication |
| rxrdy | output | 1 | Receive DMA ready indication (active low) |

## Verification
Counts, control readback, input readies and both ready outputs reflect a write, push or pop on the very next cycle. They are combinational from registered state. The overflow flags are registered, so they appear in the cycle after the offending edge and clear one cycle later. Head data and the effect of a time-out pulse are combinational and show up within the same cycle. The bench drives every input on the falling edge and samples one falling edge after the active edge. For time-out it samples a short delay after driving, within the same cycle, and again in the following cycle to check that the low level sticks.

// File: rtl/serfifo_pkg.sv
package serfifo_pkg;
  localparam int BYTE_W    = 8;
  localparam int EN_BIT    = 0;
  localparam int RXCLR_BIT = 1;
  localparam int TXCLR_BIT = 2;
  localparam int MODE_BIT  = 3;
  localparam int TRIG_LO   = 6;
  localparam int TRIG_LVL0 = 1;
  localparam int TRIG_LVL1 = 4;
  localparam int TRIG_LVL2 = 8;
  localparam int TRIG_LVL3 = 14;

  typedef struct packed {
    logic [1:0] trig;
    logic       dma_mode;
    logic       en;
  } cfg_t;
endpackage

// File: rtl/serfifo_cfg.sv
module serfifo_cfg
  import serfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output cfg_t              cfg,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic [BYTE_W-1:0] cfg_q
);
  logic arm_wr;
  logic en_drop;

  assign arm_wr  = reg_wr & reg_wdata[EN_BIT];
  assign en_drop = reg_wr & cfg.en & ~reg_wdata[EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (reg_wr) begin
      cfg.en <= reg_wdata[EN_BIT];
      if (reg_wdata[EN_BIT]) begin
        cfg.dma_mode <= reg_wdata[MODE_BIT];
        cfg.trig     <= reg_wdata[TRIG_LO+1:TRIG_LO];
      end
    end
  end

  assign rx_flush = en_drop | (arm_wr & reg_wdata[RXCLR_BIT]);
  assign tx_flush = en_drop | (arm_wr & reg_wdata[TXCLR_BIT]);

  always_comb begin
    cfg_q                       = '0;
    cfg_q[EN_BIT]               = cfg.en;
    cfg_q[MODE_BIT]             = cfg.dma_mode;
    cfg_q[TRIG_LO+1:TRIG_LO]    = cfg.trig;
  end

  // R2
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[EN_BIT]) |=> ($stable(cfg.trig) && $stable(cfg.dma_mode) && !cfg.en));
endmodule

// File: rtl/serfifo_buf.sv
module serfifo_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          pop,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop, has_data;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign has_data = (count != '0);
  assign in_ready = (count < cap);
  assign do_push  = in_valid & in_ready & ~flush;
  assign do_pop   = pop & has_data & ~flush;
  assign out_data = has_data ? mem[rptr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= in_valid & ~in_ready & ~flush;
      if (flush) begin
        wptr  <= '0;
        rptr  <= '0;
        count <= '0;
      end else begin
        if (do_push) wptr <= step(wptr);
        if (do_pop)  rptr <= step(rptr);
        case ({do_push, do_pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= in_data;
  end

  // R3
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !flush) |=> ovf);
  // R5
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == '0 && !in_valid) |=> (count == '0));
endmodule

// File: rtl/serfifo_rdy.sv
module serfifo_rdy
  import serfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cfg_t          cfg,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_timeout,
  output logic          txrdy,
  output logic          rxrdy
);
  logic [CW-1:0] trig_n;
  logic          mode1, rx_any, hit, armed_q;

  always_comb begin
    case (cfg.trig)
      2'b00:   trig_n = CW'(TRIG_LVL0);
      2'b01:   trig_n = CW'(TRIG_LVL1);
      2'b10:   trig_n = CW'(TRIG_LVL2);
      default: trig_n = CW'(TRIG_LVL3);
    endcase
  end

  assign mode1  = cfg.en & cfg.dma_mode;
  assign rx_any = (rx_count != '0);
  assign hit    = (rx_count >= trig_n) | rx_timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= mode1 & rx_any & (armed_q | hit);
  end

  assign txrdy = mode1 ? (tx_count == CW'(DEPTH)) : (tx_count != '0);
  assign rxrdy = mode1 ? (~rx_any | ~(armed_q | hit)) : ~rx_any;

  // R11
  rx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 && !rxrdy && rx_any) |=> (!rxrdy || rx_count == '0 || !mode1));
  // R11
  rx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> rxrdy);
endmodule

// File: rtl/serfifo_ctl.sv
module serfifo_ctl
  import serfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] cfg_q,
  input  logic              tx_in_valid,
  input  logic [BYTE_W-1:0] tx_in_data,
  output logic              tx_in_ready,
  input  logic              tx_pop,
  output logic [BYTE_W-1:0] tx_out_data,
  output logic [CW-1:0]     tx_count,
  output logic              tx_ovf,
  input  logic              rx_in_valid,
  input  logic [BYTE_W-1:0] rx_in_data,
  output logic              rx_in_ready,
  input  logic              rx_pop,
  output logic [BYTE_W-1:0] rx_out_data,
  output logic [CW-1:0]     rx_count,
  output logic              rx_ovf,
  input  logic              rx_timeout,
  output logic              txrdy,
  output logic              rxrdy
);
  cfg_t          cfg;
  logic          rx_flush, tx_flush;
  logic [CW-1:0] cap;

  assign cap = cfg.en ? CW'(DEPTH) : CW'(1);

  serfifo_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .cfg(cfg), .rx_flush(rx_flush), .tx_flush(tx_flush), .cfg_q(cfg_q)
  );

  serfifo_buf #(.DW(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .cap(cap),
    .in_valid(tx_in_valid), .in_data(tx_in_data), .in_ready(tx_in_ready),
    .pop(tx_pop), .out_data(tx_out_data), .count(tx_count), .ovf(tx_ovf)
  );

  serfifo_buf #(.DW(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .cap(cap),
    .in_valid(rx_in_valid), .in_data(rx_in_data), .in_ready(rx_in_ready),
    .pop(rx_pop), .out_data(rx_out_data), .count(rx_count), .ovf(rx_ovf)
  );

  serfifo_rdy #(.DEPTH(DEPTH)) u_rdy (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .tx_count(tx_count),
    .rx_count(rx_count), .rx_timeout(rx_timeout), .txrdy(txrdy), .rxrdy(rxrdy)
  );
endmodule

// File: tb/serfifo_ctl_bench.sv
module serfifo_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] cfg_q;
  logic       tx_in_valid = 1'b0;
  logic [7:0] tx_in_data = '0;
  logic       tx_in_ready;
  logic       tx_pop = 1'b0;
  logic [7:0] tx_out_data;
  logic [4:0] tx_count;
  logic       tx_ovf;
  logic       rx_in_valid = 1'b0;
  logic [7:0] rx_in_data = '0;
  logic       rx_in_ready;
  logic       rx_pop = 1'b0;
  logic [7:0] rx_out_data;
  logic [4:0] rx_count;
  logic       rx_ovf;
  logic       rx_timeout = 1'b0;
  logic       txrdy, rxrdy;

  int checks = 0;
  int errors = 0;

  localparam logic [7:0] VEC_CFG  [4] = '{8'h0B, 8'h4B, 8'h8B, 8'hCB};
  localparam int         VEC_TRIG [4] = '{1, 4, 8, 14};

  always #(CLK_PERIOD/2) clk = ~clk;

  serfifo_ctl u_serfifo_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .cfg_q(cfg_q),
    .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready),
    .tx_pop(tx_pop), .tx_out_data(tx_out_data), .tx_count(tx_count), .tx_ovf(tx_ovf),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_ready(rx_in_ready),
    .rx_pop(rx_pop), .rx_out_data(rx_out_data), .rx_count(rx_count), .rx_ovf(rx_ovf),
    .rx_timeout(rx_timeout), .txrdy(txrdy), .rxrdy(rxrdy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_in_valid = 1'b1; tx_in_data = d;
    tick();
    tx_in_valid = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_in_valid = 1'b1; rx_in_data = d;
    tick();
    rx_in_valid = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] d);
    d = tx_out_data; tx_pop = 1'b1;
    tick();
    tx_pop = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] d);
    d = rx_out_data; rx_pop = 1'b1;
    tick();
    rx_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_q", cfg_q, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 tx_in_ready", tx_in_ready, 1);
    chk("R1 rx_in_ready", rx_in_ready, 1);
    chk("R1 txrdy", txrdy, 0);
    chk("R1 rxrdy", rxrdy, 1);
    chk("R1 ovf", {tx_ovf, rx_ovf}, 0);

    // Disabled: single-byte holding
    push_tx(8'h55);
    chk("R3 disabled tx_count", tx_count, 1);
    chk("R3 disabled tx_in_ready", tx_in_ready, 0);
    chk("R12 disabled txrdy", txrdy, 1);
    push_tx(8'hAA);
    chk("R4 tx_ovf", tx_ovf, 1);
    chk("R4 tx_count kept", tx_count, 1);
    tick();
    chk("R4 tx_ovf one cycle", tx_ovf, 0);
    push_rx(8'h33);
    chk("R12 disabled rxrdy", rxrdy, 0);
    pop_rx(d);
    chk("R3 disabled rx data", d, 8'h33);
    chk("R12 rxrdy empty", rxrdy, 1);
    pop_rx(d);
    chk("R5 empty data", d, 0);
    chk("R5 empty count", rx_count, 0);
    pop_tx(d);
    chk("R3 held tx data", d, 8'h55);

    // R2 gating and readback
    wr_cfg(8'hC9);
    chk("R2 cfg_q program", cfg_q, 8'hC9);
    wr_cfg(8'h06);
    chk("R2 cfg_q gated", cfg_q, 8'hC8);
    wr_cfg(8'h07);
    chk("R2 reset bits read 0", cfg_q, 8'h01);

    // R3 full depth ordering, R10 txrdy
    for (int i = 0; i < 16; i++) push_tx(8'(i * 3 + 1));
    chk("R3 tx full count", tx_count, 16);
    chk("R3 tx full ready", tx_in_ready, 0);
    chk("R12 mode0 txrdy", txrdy, 1);
    wr_cfg(8'h09);
    chk("R10 txrdy full", txrdy, 1);
    for (int i = 0; i < 16; i++) begin
      pop_tx(d);
      chk("R3 tx order", d, i * 3 + 1);
      if (i == 0) chk("R10 txrdy one free", txrdy, 0);
    end

    // R6/R7 self-clearing flushes
    wr_cfg(8'h01);
    for (int i = 0; i < 3; i++) push_rx(8'(8'h10 + i));
    chk("R12 mode0 rxrdy", rxrdy, 0);
    push_tx(8'h21);
    push_tx(8'h22);
    reg_wr = 1'b1; reg_wdata = 8'h03;
    rx_in_valid = 1'b1; rx_in_data = 8'h77;
    tick();
    reg_wr = 1'b0; rx_in_valid = 1'b0;
    chk("R6 rx flushed over push", rx_count, 0);
    chk("R6 tx untouched", tx_count, 2);
    chk("R6 self clear", cfg_q, 8'h01);
    push_rx(8'h44);
    wr_cfg(8'h05);
    chk("R7 tx flushed", tx_count, 0);
    chk("R7 rx untouched", rx_count, 1);

    // R8 disable flush
    push_tx(8'h31);
    push_tx(8'h32);
    wr_cfg(8'h00);
    chk("R8 tx flushed", tx_count, 0);
    chk("R8 rx flushed", rx_count, 0);
    wr_cfg(8'h01);
    chk("R8 re-enable empty", {tx_count, rx_count}, 0);

    // R11 time-out and sticky low
    wr_cfg(8'hCB);
    push_rx(8'h01);
    push_rx(8'h02);
    chk("R11 below trig", rxrdy, 1);
    rx_timeout = 1'b1;
    #1;
    chk("R11 timeout low", rxrdy, 0);
    tick();
    rx_timeout = 1'b0;
    chk("R11 sticky", rxrdy, 0);
    push_rx(8'h03);
    pop_rx(d);
    pop_rx(d);
    chk("R11 sticky one left", rxrdy, 0);
    pop_rx(d);
    chk("R11 empty release", rxrdy, 1);
    push_rx(8'h04);
    chk("R11 rearm cleared", rxrdy, 1);

    // R9 threshold table
    for (int v = 0; v < 4; v++) begin
      wr_cfg(VEC_CFG[v]);
      chk("R9 flushed", rx_count, 0);
      for (int k = 1; k <= 15; k++) begin
        push_rx(8'(k));
        chk("R9 rxrdy vs level", rxrdy, (k < VEC_TRIG[v]) ? 1 : 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule